// File: doc/BRIEF.md
# Configuration-Write Snooping Bitstream Loader

This block sits passively beside a PCI bus and turns configuration-space writes that no device claims into a serial bitstream for an FPGA. Software places the payload in the low address lines of each configuration write. The block only observes the address phase; it has no bus outputs at all. The transaction therefore ends in a master abort, and the address still reaches the block intact. Software repeats the bitstream for each slot that looks empty until the target card appears.

Two address lines drive the configuration clock and data outputs of the block. Two further lines protect the loader. One line tells the block to shift instead of forward, and the other line supplies the bit shifted into an ID register. Data is passed on only while that register holds the expected ID.

The address decoder is a two-state machine. PH_IDLE means the bus is between transactions. PH_BUSY means a transaction is in progress. The transition IDLE_TO_BUSY happens on the first edge at which the frame line is sampled low, and that edge is the address phase. The transition BUSY_TO_IDLE happens on the first edge at which the frame line is sampled high again.

Top module: `cfgwr_snoop_loader`

## Requirements
- R1: After reset, `cfg_clk_o`, `cfg_dat_o` and `id_ok_o` are 0 and the ID register is all zeros.
- R2: An address phase is decoded only if `bus_cmd_n` equals 4'b1011 (configuration write) and `bus_ad[1:0]` equals 2'b00 (type 0). Any other command or type leaves the ID register, `id_ok_o` and both configuration outputs unchanged, whatever the other address bits hold.
- R3: Only the edge at which the machine is in PH_IDLE and `bus_frame_n` is sampled low counts as an address phase. Later edges of the same transaction with `bus_frame_n` still low are ignored, even when they carry a configuration-write command and payload bits.
- R4: A decoded write with `bus_ad[4]`=0 while the ID matches sets `cfg_clk_o` to `bus_ad[2]` and `cfg_dat_o` to `bus_ad[3]` on that clock edge. Both outputs then hold until the next decoded write.
- R5: A decoded write with `bus_ad[4]`=1 shifts `bus_ad[5]` into the least significant bit of the 16-bit ID register. The older bits move up by one place and the oldest bit is discarded. On that write `cfg_clk_o` does not rise, even if `bus_ad[2]` is 1.
- R6: `id_ok_o` is a registered output. It is 1 exactly when the 16 most recently shifted bits equal ID_VALUE (default 16'hA5C3), with the last shifted bit in the LSB. It takes its new value on the same edge as the shift, so bits shifted in earlier make no difference.
- R7: While the ID does not match, `cfg_clk_o` and `cfg_dat_o` are both 0. A shift that breaks the match clears both on that edge. After the match is regained, both stay 0 until a data write arrives.
- R8: When a transaction ends, one cycle with `bus_frame_n` high is enough to return to PH_IDLE. A transaction that starts on the very next edge is decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_frame_n | input | 1 | Observed frame line, active low |
| bus_cmd_n | input | 4 | Observed command / byte-enable lines |
| bus_ad | input | ADDR_W (6) | Observed low address/data lines |
| cfg_clk_o | output | 1 | Serial configuration clock toward the FPGA |
| cfg_dat_o | output | 1 | Serial configuration data toward the FPGA |
| id_ok_o | output | 1 | Registered ID-match flag |

## Verification
The bench sweeps every command code and both non-zero address types while a match is active. A decoder that ignored the command or the type would then load payload from ordinary reads or memory writes. It drives extra data beats with the frame line held low and the payload bits flipped. A machine that re-decoded mid-transaction would then show the flipped values. It shifts four junk bits before the ID, shifts with the clock bit set, and breaks the match after data has been loaded. These steps catch a comparison against stale history, a clock pulse leaking out on a shift, and forward data left standing after the ID is lost. All transactions run back to back with a single idle cycle, so a machine that needed a longer gap would miss writes.

// File: rtl/cfgsnoop_pkg.sv
package cfgsnoop_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_t;

    localparam logic [3:0] CMD_CFG_WR = 4'b1011;
    localparam logic [1:0] CFG_TYPE0  = 2'b00;

endpackage

// File: rtl/cfgsnoop_phase.sv
module cfgsnoop_phase
    import cfgsnoop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic [3:0] cmd_n,
    input  logic [1:0] addr_type,
    output logic       addr_phase,
    output logic       cfg_hit
);

    phase_t state_q;
    phase_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (!frame_n) state_d = PH_BUSY;   // IDLE_TO_BUSY
            PH_BUSY: if (frame_n)  state_d = PH_IDLE;   // BUSY_TO_IDLE
            default:               state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        addr_phase = 1'b0;
        cfg_hit    = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                addr_phase = !frame_n;
                cfg_hit    = !frame_n && (cmd_n == CMD_CFG_WR) && (addr_type == CFG_TYPE0);
            end
            PH_BUSY: begin
                addr_phase = 1'b0;
                cfg_hit    = 1'b0;
            end
            default: begin
                addr_phase = 1'b0;
                cfg_hit    = 1'b0;
            end
        endcase
    end

    // R3
    phase_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> !addr_phase);

    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_BUSY && frame_n) |=> (state_q == PH_IDLE));

endmodule

// File: rtl/cfgsnoop_idreg.sv
module cfgsnoop_idreg #(
    parameter int              ID_W     = 16,
    parameter logic [ID_W-1:0] ID_VALUE = 16'hA5C3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic shift_bit,
    output logic match_nxt,
    output logic match_q
);

    logic [ID_W-1:0] id_q;
    logic [ID_W-1:0] id_d;

    always_comb begin
        id_d      = shift_en ? {id_q[ID_W-2:0], shift_bit} : id_q;
        match_nxt = (id_d == ID_VALUE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q    <= '0;
            match_q <= 1'b0;
        end else begin
            id_q    <= id_d;
            match_q <= match_nxt;
        end
    end

    // R5
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (id_q[0] == $past(shift_bit)) &&
                     (id_q[ID_W-1:1] == $past(id_q[ID_W-2:0])));

    // R2
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(id_q));

    // R6
    match_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_q == (id_q == ID_VALUE));

endmodule

// File: rtl/cfgsnoop_cfgout.sv
module cfgsnoop_cfgout (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic shift_req,
    input  logic match_nxt,
    input  logic clk_bit,
    input  logic dat_bit,
    output logic cfg_clk_o,
    output logic cfg_dat_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_clk_o <= 1'b0;
            cfg_dat_o <= 1'b0;
        end else if (!match_nxt) begin
            cfg_clk_o <= 1'b0;
            cfg_dat_o <= 1'b0;
        end else if (hit && !shift_req) begin
            cfg_clk_o <= clk_bit;
            cfg_dat_o <= dat_bit;
        end
    end

    // R5
    shift_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && shift_req) |=> !$rose(cfg_clk_o));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && match_nxt) |=> ($stable(cfg_clk_o) && $stable(cfg_dat_o)));

endmodule

// File: rtl/cfgwr_snoop_loader.sv
module cfgwr_snoop_loader #(
    parameter int              ADDR_W    = 6,
    parameter int              ID_W      = 16,
    parameter logic [ID_W-1:0] ID_VALUE  = 16'hA5C3,
    parameter int              CLK_POS   = 2,
    parameter int              DAT_POS   = 3,
    parameter int              SHEN_POS  = 4,
    parameter int              SHVAL_POS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_frame_n,
    input  logic [3:0]        bus_cmd_n,
    input  logic [ADDR_W-1:0] bus_ad,
    output logic              cfg_clk_o,
    output logic              cfg_dat_o,
    output logic              id_ok_o
);

    logic addr_phase;
    logic cfg_hit;
    logic shift_en;
    logic match_nxt;

    cfgsnoop_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (bus_frame_n),
        .cmd_n      (bus_cmd_n),
        .addr_type  (bus_ad[1:0]),
        .addr_phase (addr_phase),
        .cfg_hit    (cfg_hit)
    );

    assign shift_en = cfg_hit && bus_ad[SHEN_POS];

    cfgsnoop_idreg #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_idreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .shift_bit (bus_ad[SHVAL_POS]),
        .match_nxt (match_nxt),
        .match_q   (id_ok_o)
    );

    cfgsnoop_cfgout u_cfgout (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (cfg_hit),
        .shift_req (bus_ad[SHEN_POS]),
        .match_nxt (match_nxt),
        .clk_bit   (bus_ad[CLK_POS]),
        .dat_bit   (bus_ad[DAT_POS]),
        .cfg_clk_o (cfg_clk_o),
        .cfg_dat_o (cfg_dat_o)
    );

    // R7
    locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_ok_o |-> (!cfg_clk_o && !cfg_dat_o));

    // R3
    busy_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> !cfg_hit);

endmodule

// File: tb/cfgwr_snoop_loader_tb_top.sv
`timescale 1ns/1ps
module cfgwr_snoop_loader_tb_top;

    localparam logic [15:0] EXP_ID = 16'hA5C3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_frame_n = 1'b1;
    logic [3:0] bus_cmd_n = 4'b0000;
    logic [5:0] bus_ad = 6'b0;
    logic       cfg_clk_o, cfg_dat_o, id_ok_o;

    int total = 0;
    int bad = 0;

    logic [15:0] m_id = '0;
    logic        m_ok = 1'b0;
    logic        m_clk = 1'b0;
    logic        m_dat = 1'b0;

    always #2.5 clk = ~clk;

    cfgwr_snoop_loader dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_frame_n (bus_frame_n),
        .bus_cmd_n   (bus_cmd_n),
        .bus_ad      (bus_ad),
        .cfg_clk_o   (cfg_clk_o),
        .cfg_dat_o   (cfg_dat_o),
        .id_ok_o     (id_ok_o)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "cfg_clk_o", cfg_clk_o, m_clk);
        check(req, "cfg_dat_o", cfg_dat_o, m_dat);
        check(req, "id_ok_o", id_ok_o, m_ok);
    endtask

    // Starts at a falling edge, ends at the falling edge after the last data phase.
    task automatic bus_cycle(input logic [3:0] cmd, input logic [5:0] a, input int stuck);
        bus_frame_n = 1'b0;
        bus_cmd_n   = cmd;
        bus_ad      = a;
        for (int i = 0; i < stuck; i++) begin
            @(negedge clk);
            bus_frame_n = 1'b0;
            bus_cmd_n   = 4'b1011;
            bus_ad      = a ^ 6'b111100;
        end
        @(negedge clk);
        bus_frame_n = 1'b1;
        bus_cmd_n   = 4'b0000;
        bus_ad      = a ^ 6'b111100;
        @(negedge clk);
        bus_ad      = 6'b0;
        if (cmd == 4'b1011 && a[1:0] == 2'b00) begin
            if (a[4]) m_id = {m_id[14:0], a[5]};
            m_ok = (m_id == EXP_ID);
            if (!m_ok) begin
                m_clk = 1'b0;
                m_dat = 1'b0;
            end else if (!a[4]) begin
                m_clk = a[2];
                m_dat = a[3];
            end
        end
    endtask

    task automatic shift_one(input logic b);
        bus_cycle(4'b1011, {b, 1'b1, 4'b0100}, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R7: data writes while locked produce nothing
        for (int v = 0; v < 4; v++) begin
            bus_cycle(4'b1011, {2'b00, v[1:0], 2'b00}, 0);
            check_all("R7");
        end

        // R5/R6: junk prefix then the ID, clock bit set on every shift
        for (int j = 0; j < 4; j++) begin
            shift_one(j[0]);
            check_all("R5");
        end
        for (int k = 15; k >= 0; k--) begin
            shift_one(EXP_ID[k]);
            check_all("R6");
        end
        check("R6", "id_ok_o after full ID", id_ok_o, 1'b1);

        // R7: regained match, outputs still 0 until a data write
        check("R7", "cfg_clk_o before data", cfg_clk_o, 1'b0);

        // R4 + R3: all payload pairs, with stuck frame beats carrying flipped bits
        for (int v = 0; v < 4; v++) begin
            bus_cycle(4'b1011, {2'b00, v[1:0], 2'b00}, 2);
            check_all("R4");
            check_all("R3");
        end

        // R2: every command code, payload opposite to the current outputs
        for (int c = 0; c < 16; c++) begin
            bus_cycle(4'b1011, 6'b000100, 0);
            bus_cycle(c[3:0], 6'b001000, 1);
            check_all("R2");
        end
        // R2: non-zero address types ignored, including a shift request
        bus_cycle(4'b1011, 6'b001100, 0);
        bus_cycle(4'b1011, 6'b000001, 0);
        check_all("R2");
        bus_cycle(4'b1011, 6'b010010, 0);
        check_all("R2");
        bus_cycle(4'b0111, 6'b010000, 0);
        check_all("R2");

        // R8: back-to-back writes with one idle cycle
        bus_cycle(4'b1011, 6'b000100, 0);
        bus_cycle(4'b1011, 6'b001000, 0);
        check_all("R8");
        bus_cycle(4'b1011, 6'b001100, 0);
        check_all("R8");

        // R7: shift breaks the match and clears the outputs
        shift_one(1'b0);
        check_all("R7");
        check("R7", "cfg_dat_o after lost match", cfg_dat_o, 1'b0);
        bus_cycle(4'b1011, 6'b001100, 0);
        check_all("R7");

        // R6: re-enter the ID, then forward again
        for (int k = 15; k >= 0; k--) shift_one(EXP_ID[k]);
        check_all("R6");
        bus_cycle(4'b1011, 6'b001000, 0);
        check_all("R4");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule